// File: doc/BRIEF.md
# ADC Output Formatter with Demultiplexer

This block sits after one 8-bit converter channel and shapes its sample stream for the output pins. On every converter clock it can accept one code and an over-range flag. When selected, the code is translated to Gray code. The stream then leaves on one 8-bit port at the full rate (1:1). It can instead be split into pairs and placed on two 8-bit ports, A and B, at half the rate (1:2).

A data-ready strobe marks every new output word by changing level. A 2-bit setting delays the strobe and the data by zero to three converter clocks. A test mode keeps one sample in 4, 8, 16 or 32 and drops the rest. An active-low asynchronous reset clears the strobe, the pair phase and the decimation count, which lines up the output pairing again. Configuration inputs are expected to change only while reset is asserted.

Top module: `adc_out_fmt`

## Requirements
- R1: While `rst_n` is low, `out_a`, `out_b`, `ovr_a`, `ovr_b` and `dready` are 0. They clear at once when reset is asserted, without waiting for a clock edge.
- R2: With `gray_en`=0, `demux2`=0, `dec_en`=0 and `dly`=0, a code on `in_code` appears unchanged on `out_a` after the clock edge that captures it.
- R3: With `gray_en`=1, the output code is `b ^ (b >> 1)` for the input code `b`.
- R4: The over-range flag is never encoded. It travels with its own sample, on `ovr_a` for data on `out_a` and on `ovr_b` for data on `out_b`.
- R5: `dready` inverts once for each new output word and holds otherwise. In 1:1 mode with no decimation, it inverts on every clock.
- R6: With `demux2`=1, the earlier sample of each pair goes to `out_a` and the later one to `out_b`. Both ports update on the edge that captures the later sample, and `dready` inverts once per pair.
- R7: After reset, the first kept sample is the earlier sample of a pair. A sample left pending before reset is discarded.
- R8: A `dly` value d from 0 to 3 delays the data, the flags and `dready` by exactly d clocks.
- R9: With `dec_en`=1, `dec_sel` values 0, 1, 2 and 3 select factors 4, 8, 16 and 32. The first sample after reset is kept, then every Nth sample. Samples in between leave the outputs unchanged.
- R10: In 1:1 mode, `out_b` and `ovr_b` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter sample clock |
| rst_n | input | 1 | Asynchronous active-low reset of strobe, phase and counters |
| in_code | input | 8 | Converter output code |
| in_ovr | input | 1 | Over-range flag for in_code |
| gray_en | input | 1 | 1 selects Gray output coding |
| demux2 | input | 1 | 1 selects the two-port 1:2 output |
| dly | input | 2 | Data-ready and data delay in clocks |
| dec_en | input | 1 | 1 enables the decimation test mode |
| dec_sel | input | 2 | Decimation factor 4 << dec_sel |
| out_a | output | 8 | Port A data (earlier sample of a pair) |
| out_b | output | 8 | Port B data (later sample of a pair) |
| ovr_a | output | 1 | Over-range flag for out_a |
| ovr_b | output | 1 | Over-range flag for out_b |
| dready | output | 1 | Data-ready strobe, inverts per output word |

## Verification
The hardest case to reach is a reset that lands between the two halves of a pair. The earlier sample is already held inside, and the outputs alone cannot show that it is pending. The stimulus first completes one pair in 1:2 mode, then feeds one more sample and asserts reset halfway through the clock period. It checks that the outputs cleared before the next edge. It then feeds a fresh pair and confirms that the pending sample did not end up on port A. The longest decimation factor is also run through a full 32-sample window, to show that the dropped samples never disturb the held word.

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int W    = 8,
  parameter int DLYW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_code,
  input  logic         in_ovr,
  input  logic         gray_en,
  input  logic         demux2,
  input  logic [DLYW-1:0] dly,
  input  logic         dec_en,
  input  logic [1:0]   dec_sel,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic         ovr_a,
  output logic         ovr_b,
  output logic         dready
);
  localparam int DEPTH = (1 << DLYW) - 1;
  localparam int WW    = 2 * W + 3;

  logic [4:0] dec_cnt;
  logic [4:0] dec_last;
  logic       keep;
  logic [W-1:0] coded;
  logic       phase;
  logic [W-1:0] hold;
  logic       hold_ovr;
  logic [WW-1:0] stage [0:DEPTH];
  logic [WW-1:0] tap;

  assign dec_last = 5'((6'd4 << dec_sel) - 6'd1);
  assign keep     = !dec_en || (dec_cnt == 5'd0);
  assign coded    = gray_en ? (in_code ^ (in_code >> 1)) : in_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dec_cnt <= '0;
    else if (!dec_en || dec_cnt == dec_last)
      dec_cnt <= '0;
    else
      dec_cnt <= dec_cnt + 5'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      hold     <= '0;
      hold_ovr <= 1'b0;
      stage[0] <= '0;
    end else if (keep) begin
      if (demux2) begin
        if (!phase) begin
          hold     <= coded;
          hold_ovr <= in_ovr;
          phase    <= 1'b1;
        end else begin
          stage[0] <= {hold, coded, hold_ovr, in_ovr, ~stage[0][0]};
          phase    <= 1'b0;
        end
      end else begin
        stage[0] <= {coded, {W{1'b0}}, in_ovr, 1'b0, ~stage[0][0]};
      end
    end
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign tap    = stage[dly];
  assign out_a  = tap[WW-1 -: W];
  assign out_b  = tap[W+2 -: W];
  assign ovr_a  = tap[2];
  assign ovr_b  = tap[1];
  assign dready = tap[0];
endmodule

// File: rtl/adc_out_fmt_chk.sv
module adc_out_fmt_chk #(
  parameter int W    = 8,
  parameter int DLYW = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         demux2,
  input logic         dec_en,
  input logic [DLYW-1:0] dly,
  input logic [W-1:0] out_a,
  input logic [W-1:0] out_b,
  input logic         ovr_b,
  input logic         dready
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (out_a == '0 && out_b == '0 && !dready));

  a_r5_toggle_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!demux2 && !dec_en && dly == '0) |=> (dready != $past(dready)));

  a_r6_data_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (out_a != $past(out_a) || out_b != $past(out_b)) |-> (dready != $past(dready)));

  a_r10_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !demux2 |-> (out_b == '0 && !ovr_b));
endmodule

bind adc_out_fmt adc_out_fmt_chk #(.W(W), .DLYW(DLYW)) u_chk (
  .clk(clk), .rst_n(rst_n), .demux2(demux2), .dec_en(dec_en), .dly(dly),
  .out_a(out_a), .out_b(out_b), .ovr_b(ovr_b), .dready(dready)
);

// File: tb/sim_adc_out_fmt.sv
module sim_adc_out_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] in_code = '0;
  logic       in_ovr = 1'b0, gray_en = 1'b0, demux2 = 1'b0, dec_en = 1'b0;
  logic [1:0] dly = '0, dec_sel = '0;
  logic [7:0] out_a, out_b;
  logic       ovr_a, ovr_b, dready;
  int checks = 0, errors = 0;

  adc_out_fmt u0 (.clk(clk), .rst_n(rst_n), .in_code(in_code), .in_ovr(in_ovr),
    .gray_en(gray_en), .demux2(demux2), .dly(dly), .dec_en(dec_en), .dec_sel(dec_sel),
    .out_a(out_a), .out_b(out_b), .ovr_a(ovr_a), .ovr_b(ovr_b), .dready(dready));

  always #4 clk = ~clk;

  // {gray_en, ovr, code}
  localparam logic [9:0] VEC [0:7] = '{
    {1'b0, 1'b0, 8'h00}, {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'h5A}, {1'b1, 1'b0, 8'h80},
    {1'b1, 1'b1, 8'hFF}, {1'b1, 1'b0, 8'h37}, {1'b0, 1'b1, 8'h81}, {1'b1, 1'b0, 8'h01}};

  function automatic logic [7:0] gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] c, input logic o);
    in_code = c; in_ovr = o;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic prev;
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out_a", out_a, 0); chk("R1 dready", dready, 0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R10: table walk in 1:1 mode
    for (int i = 0; i < 8; i++) begin
      prev = dready;
      gray_en = VEC[i][9];
      step(VEC[i][7:0], VEC[i][8]);
      chk("R2/R3 out_a", out_a, VEC[i][9] ? gray(VEC[i][7:0]) : VEC[i][7:0]);
      chk("R4 ovr_a", ovr_a, VEC[i][8]);
      chk("R5 dready", dready, !prev);
      chk("R10 out_b", {ovr_b, out_b}, 0);
    end
    gray_en = 1'b0;

    // R6: 1:2 pairing
    demux2 = 1'b1;
    do_reset();
    step(8'h11, 1'b1);
    chk("R6 hold a", out_a, 0); chk("R6 hold dready", dready, 0);
    step(8'h22, 1'b0);
    chk("R6 out_a", out_a, 8'h11); chk("R6 out_b", out_b, 8'h22);
    chk("R4 ovr pair", {ovr_a, ovr_b}, 2'b10); chk("R6 dready", dready, 1);
    step(8'h33, 1'b0);
    chk("R6 half rate", dready, 1);
    step(8'h44, 1'b1);
    chk("R6 second pair", {out_a, out_b}, 16'h3344); chk("R6 dready2", dready, 0);

    // R7 R1: reset mid-pair, async clear
    step(8'h77, 1'b0);
    #1 rst_n = 1'b0;
    #1 chk("R1 async clear", {out_a, out_b, dready}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(8'h55, 1'b0);
    chk("R7 pending dropped", out_a, 0);
    step(8'h66, 1'b0);
    chk("R7 realign", {out_a, out_b}, 16'h5566);

    // R8: delay 3 in 1:1
    demux2 = 1'b0; dly = 2'd3;
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    step(8'hA5, 1'b1);
    for (int k = 0; k < 2; k++) begin
      step(8'h00, 1'b0);
      chk("R8 not yet", {out_a, dready}, 0);
    end
    step(8'h00, 1'b0);
    chk("R8 delayed data", out_a, 8'hA5); chk("R8 delayed ovr", ovr_a, 1);
    chk("R8 delayed dready", dready, 1);
    dly = 2'd0;

    // R9: decimation by 4
    dec_en = 1'b1; dec_sel = 2'd0;
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    step(8'h10, 1'b0);
    chk("R9 first kept", out_a, 8'h10);
    for (int k = 1; k < 4; k++) begin
      step(8'h10 + 8'(k), 1'b0);
      chk("R9 dropped", out_a, 8'h10);
    end
    step(8'h14, 1'b0);
    chk("R9 fourth kept", out_a, 8'h14);

    // R9: decimation by 32
    dec_sel = 2'd3;
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    step(8'h01, 1'b0);
    for (int k = 1; k < 32; k++) step(8'h02, 1'b1);
    chk("R9 x32 held", {ovr_a, out_a}, 9'h001); chk("R9 x32 dready", dready, 1);
    step(8'h99, 1'b0);
    chk("R9 x32 kept", out_a, 8'h99); chk("R9 x32 dready2", dready, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule